// File: doc/BRIEF.md
# SPI Event Collection and Interrupt Masking Unit

This unit gathers the nine status events of an SPI master (transfer engine and FIFO conditions) into a sticky event register. Software clears events by writing ones to an acknowledge port. A separate mask register blocks selected events from reaching the interrupt. The unit drives one interrupt line and a device-pending status bit. The status bit is set whenever any event is pending and not masked.

Each event arrives as a single-cycle strobe and stays latched until it is acknowledged. An event latches whether or not it is masked, so software can poll masked conditions. The unit clears receive and transmit request events one bit at a time without touching the other pending events. This lets FIFO service loops acknowledge requests while error or done events stay visible.

Top module: `spi_evt_irq_unit`

## Requirements
- R1: While `rst` is high and after it falls, the unit shows `evt_q` = 0, `mask_q` = all ones (every event blocked), `irq` = 0 and `dev_pending` = 0.
- R2: A strobe on `evt_strobe[i]` sets `evt_q[i]` at the next clock edge, and the bit stays set until it is acknowledged. Bit positions:
  - 0 master done
  - 1 slave done
  - 2 transmit request
  - 3 transmit overflow
  - 4 transmit underflow
  - 5 receive request
  - 6 receive overflow
  - 7 receive underflow
  - 8 multiple-master error
- R3: When `ack_we` is high, each `ack_wdata` bit written as 1 clears the matching event bit at the next edge. Bits written as 0 are left unchanged.
- R4: When a strobe and an acknowledge of the same bit occur in the same cycle, the bit stays set.
- R5: A masked event (mask bit = 1) still latches into `evt_q` but does not raise `dev_pending` or `irq`.
- R6: `dev_pending` equals the OR over all bits of (`evt_q` AND NOT `mask_q`), and it updates on the same edge as those registers.
- R7: `irq` is a registered copy of `dev_pending`, one clock later.
- R8: With all mask bits set, `dev_pending` and `irq` stay 0 whatever events are latched.
- R9: When `mask_we` is high, `mask_wdata` is loaded into `mask_q` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | 9 | Single-cycle event strobes |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 9 | Mask write data, 1 blocks the event |
| ack_we | input | 1 | Event acknowledge write enable |
| ack_wdata | input | 9 | Write-one-to-clear acknowledge data |
| evt_q | output | 9 | Latched event register |
| mask_q | output | 9 | Mask register |
| dev_pending | output | 1 | Any unmasked event pending |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench acknowledges one request bit while two other events stay pending. A design that cleared the whole register, or ignored the write data, would lose the done event. It strobes and acknowledges the same bit in one cycle. A design where the clear takes priority would drop an event that arrived in that cycle. It latches events under a partial mask and under the full mask, then lifts the mask. A design that gated events before latching them would show nothing when the mask is lifted. A design that leaked masked events would raise the line while they are blocked. The bench also times `irq` against `dev_pending`, which catches a missing or extra register stage.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int SPI_EVT_COUNT = 9;
endpackage

// File: rtl/spi_evt_cell.sv
module spi_evt_cell (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic ack,
  output logic nxt,
  output logic q
);
  // a new strobe outranks a simultaneous acknowledge
  always_comb begin
    nxt = q;
    if (ack)    nxt = 1'b0;
    if (strobe) nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end
endmodule

// File: rtl/spi_irq_mask_reg.sv
module spi_irq_mask_reg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ALL_BLOCKED = {W{1'b1}};

  always_comb nxt = we ? wdata : q;

  always_ff @(posedge clk) begin
    if (rst) q <= ALL_BLOCKED;
    else     q <= nxt;
  end
endmodule

// File: rtl/spi_irq_combine.sv
module spi_irq_combine #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_nxt,
  input  logic [W-1:0] mask_nxt,
  output logic         pending_q,
  output logic         irq_q
);
  logic [W-1:0] live;

  always_comb live = evt_nxt & ~mask_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      pending_q <= |live;
      irq_q     <= pending_q;
    end
  end
endmodule

// File: rtl/spi_evt_irq_unit.sv
module spi_evt_irq_unit #(
  parameter int NUM_EVT = spi_irq_pkg::SPI_EVT_COUNT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic               mask_we,
  input  logic [NUM_EVT-1:0] mask_wdata,
  input  logic               ack_we,
  input  logic [NUM_EVT-1:0] ack_wdata,
  output logic [NUM_EVT-1:0] evt_q,
  output logic [NUM_EVT-1:0] mask_q,
  output logic               dev_pending,
  output logic               irq
);
  logic [NUM_EVT-1:0] evt_nxt;
  logic [NUM_EVT-1:0] mask_nxt;
  logic [NUM_EVT-1:0] ack_bits;

  always_comb ack_bits = ack_we ? ack_wdata : '0;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    spi_evt_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .strobe (evt_strobe[i]),
      .ack    (ack_bits[i]),
      .nxt    (evt_nxt[i]),
      .q      (evt_q[i])
    );
  end

  spi_irq_mask_reg #(.W(NUM_EVT)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .we    (mask_we),
    .wdata (mask_wdata),
    .nxt   (mask_nxt),
    .q     (mask_q)
  );

  spi_irq_combine #(.W(NUM_EVT)) u_comb (
    .clk       (clk),
    .rst       (rst),
    .evt_nxt   (evt_nxt),
    .mask_nxt  (mask_nxt),
    .pending_q (dev_pending),
    .irq_q     (irq)
  );
endmodule

// File: rtl/spi_evt_irq_chk.sv
module spi_evt_irq_chk #(
  parameter int NUM_EVT = 9
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_EVT-1:0] evt_strobe,
  input logic               mask_we,
  input logic [NUM_EVT-1:0] mask_wdata,
  input logic               ack_we,
  input logic [NUM_EVT-1:0] ack_wdata,
  input logic [NUM_EVT-1:0] evt_q,
  input logic [NUM_EVT-1:0] mask_q,
  input logic               dev_pending,
  input logic               irq
);
  logic [NUM_EVT-1:0] acked;
  always_comb acked = ack_we ? ack_wdata : '0;

  // R2 and R4: a strobed bit is set at the next edge, even if acknowledged
  assert_strobe_sets_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((evt_q & $past(evt_strobe)) == $past(evt_strobe)));

  // R2: a set bit that was not acknowledged stays set
  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((evt_q & $past(evt_q & ~acked)) == $past(evt_q & ~acked)));

  // R3: an acknowledged bit with no new strobe is cleared
  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (rst)
    ack_we |=> ((evt_q & $past(ack_wdata & ~evt_strobe)) == '0));

  // R6: the pending status tracks the unmasked events
  assert_pending_R6: assert property (@(posedge clk) disable iff (rst)
    dev_pending == (|(evt_q & ~mask_q)));

  // R7: the interrupt line lags the status by one clock
  assert_irq_lag_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(dev_pending)));

  // R8: everything masked means no pending status
  assert_all_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |-> !dev_pending);

  // R9: a mask write lands at the next edge
  assert_mask_load_R9: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (mask_q == $past(mask_wdata)));
endmodule

bind spi_evt_irq_unit spi_evt_irq_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .evt_strobe  (evt_strobe),
  .mask_we     (mask_we),
  .mask_wdata  (mask_wdata),
  .ack_we      (ack_we),
  .ack_wdata   (ack_wdata),
  .evt_q       (evt_q),
  .mask_q      (mask_q),
  .dev_pending (dev_pending),
  .irq         (irq)
);

// File: tb/spi_evt_irq_unit_test.sv
module spi_evt_irq_unit_test;
  localparam int N = 9;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] evt_strobe = '0;
  logic         mask_we = 1'b0;
  logic [N-1:0] mask_wdata = '0;
  logic         ack_we = 1'b0;
  logic [N-1:0] ack_wdata = '0;
  logic [N-1:0] evt_q;
  logic [N-1:0] mask_q;
  logic         dev_pending;
  logic         irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  spi_evt_irq_unit #(.NUM_EVT(N)) uut (
    .clk(clk), .rst(rst), .evt_strobe(evt_strobe),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .ack_we(ack_we), .ack_wdata(ack_wdata),
    .evt_q(evt_q), .mask_q(mask_q),
    .dev_pending(dev_pending), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, release at the next falling edge
  task automatic step(input logic [N-1:0] stb, input logic mwe, input logic [N-1:0] md,
                      input logic awe, input logic [N-1:0] ad);
    evt_strobe = stb; mask_we = mwe; mask_wdata = md; ack_we = awe; ack_wdata = ad;
    @(posedge clk);
    @(negedge clk);
    evt_strobe = '0; mask_we = 1'b0; ack_we = 1'b0;
  endtask

  task automatic idle();
    step('0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic t_reset();
    chk("R1 evt during reset", evt_q, 0);
    chk("R1 mask during reset", mask_q, 9'h1FF);
    @(negedge clk); rst = 1'b0;
    idle();
    chk("R1 evt", evt_q, 0);
    chk("R1 mask", mask_q, 9'h1FF);
    chk("R1 irq", irq, 0);
    chk("R1 pending", dev_pending, 0);
  endtask

  task automatic t_latch_hold();
    step('0, 1'b1, 9'h000, 1'b0, '0);
    chk("R9 mask load", mask_q, 9'h000);
    step(9'h004, 1'b0, '0, 1'b0, '0);
    chk("R2 latch", evt_q, 9'h004);
    chk("R6 pending same edge", dev_pending, 1);
    chk("R7 irq not yet", irq, 0);
    idle();
    chk("R7 irq one clock later", irq, 1);
    idle(); idle();
    chk("R2 held", evt_q, 9'h004);
    step('0, 1'b0, '0, 1'b1, 9'h004);
    chk("R3 clear", evt_q, 0);
    chk("R6 pending drops", dev_pending, 0);
    idle();
    chk("R7 irq drops", irq, 0);
  endtask

  task automatic t_ack_selective();
    step(9'h021, 1'b0, '0, 1'b0, '0);
    step(9'h004, 1'b0, '0, 1'b0, '0);
    chk("R2 accumulate", evt_q, 9'h025);
    step('0, 1'b0, '0, 1'b1, 9'h004);
    chk("R3 tx request only", evt_q, 9'h021);
    step('0, 1'b0, '0, 1'b1, 9'h020);
    chk("R3 rx request only", evt_q, 9'h001);
    chk("R6 done still pending", dev_pending, 1);
    step('0, 1'b0, '0, 1'b1, 9'h001);
    chk("R3 last clear", evt_q, 0);
  endtask

  task automatic t_set_wins();
    step(9'h100, 1'b0, '0, 1'b0, '0);
    step(9'h100, 1'b0, '0, 1'b1, 9'h100);
    chk("R4 strobe beats ack", evt_q, 9'h100);
    step(9'h002, 1'b0, '0, 1'b1, 9'h100);
    chk("R4 other bit strobe, ack clears", evt_q, 9'h002);
    step('0, 1'b0, '0, 1'b1, 9'h1FF);
    chk("R3 clear all", evt_q, 0);
  endtask

  task automatic t_masked_latch();
    step('0, 1'b1, 9'h0F0, 1'b0, '0);
    step(9'h010, 1'b0, '0, 1'b0, '0);
    chk("R5 masked latches", evt_q, 9'h010);
    chk("R5 no pending", dev_pending, 0);
    idle();
    chk("R5 no irq", irq, 0);
    step('0, 1'b1, 9'h000, 1'b0, '0);
    chk("R6 unmask exposes", dev_pending, 1);
    idle();
    chk("R7 irq after unmask", irq, 1);
    step('0, 1'b0, '0, 1'b1, 9'h010);
    chk("R3 masked clear", evt_q, 0);
  endtask

  task automatic t_all_masked();
    step('0, 1'b1, 9'h1FF, 1'b0, '0);
    step(9'h1FF, 1'b0, '0, 1'b0, '0);
    chk("R8 all latched", evt_q, 9'h1FF);
    chk("R8 no pending", dev_pending, 0);
    idle();
    chk("R8 no irq", irq, 0);
    step('0, 1'b0, '0, 1'b1, 9'h1FF);
    chk("R3 clear after mask", evt_q, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_latch_hold();
    t_ack_selective();
    t_set_wins();
    t_masked_latch();
    t_all_masked();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule